// File: doc/BRIEF.md
# Transition Coverage Monitor

The monitor samples a vector of circuit variables once per applied test. The vector holds primary inputs, internal nodes and observable outputs. Whenever a new sample arrives it compares the sample with the previous one. It reports, for every variable, whether that variable went up, went down or held. It also reports which input variable was toggled to reach the new test point. The per-variable codes together form one row of a diagnostic table.

Two masks describe the roles of the bits. One mask marks the bits that are stimulus inputs and the other marks the bits that are observable outputs. Each step is checked against two rules. A legal step toggles exactly one input, and a useful step moves at least one observable output. Only steps that pass both rules count toward coverage.

A variable counts as covered once it has been seen both rising and falling on counted steps. A summary flag goes high when every variable is covered. A synchronous clear input restarts the whole collection.

Top module: `toggle_cov_mon`

## Requirements
- R1: After reset or a clear, `step_valid`, `step_codes`, `step_var`, `proto_err`, `obs_err` and `cov_flags` are all zero. The first sample after a clear only loads the previous-value register and raises no `step_valid`.
- R2: For each later sample, `step_valid` is high for exactly the next cycle. Field i of `step_codes` (bits 2i+1:2i) is 2'b01 when variable i went 0 to 1, 2'b10 when it went 1 to 0, and 2'b00 when it held. The code 2'b11 never appears.
- R3: `step_var` gives the index of the input-mask bit that changed. When several input bits changed it gives the lowest such index, and when none changed it gives 0.
- R4: `proto_err` is high on a step where the number of changed input-mask bits is not exactly one.
- R5: `obs_err` is high on a step where no output-mask bit changed.
- R6: A step updates the coverage state only when both `proto_err` and `obs_err` are low. Bit i of `cov_flags` rises once variable i has shown both a rise and a fall on such steps, and it stays high until a clear.
- R7: `all_cov` is high exactly when every bit of `cov_flags` is high.
- R8: When `clr` and `smp_valid` are both high in the same cycle, the clear wins and the sample is discarded.
- R9: In a cycle without `smp_valid`, `step_valid` is low and the step outputs and coverage state keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of collection |
| smp_valid | input | 1 | A new test sample is present |
| smp_vec | input | N | Sampled circuit variables |
| in_mask | input | N | Bits that are stimulus inputs |
| obs_mask | input | N | Bits that are observable outputs |
| step_valid | output | 1 | A classification was produced last cycle |
| step_codes | output | 2N | Per-variable rise/fall/hold codes |
| step_var | output | IW | Index of the toggled input |
| proto_err | output | 1 | Step changed zero or several inputs |
| obs_err | output | 1 | Step moved no observable output |
| cov_flags | output | N | Per-variable bidirectional coverage |
| all_cov | output | 1 | Every variable covered |

## Verification
Most steps are random single-input toggles with random motion on the internal and output bits. These exercise the code encoding and the index report across all bit positions. Some random steps toggle no input or two inputs, and others leave the output still. Comparing these against legal steps shows that an illegal step is flagged and that its transitions are kept out of coverage. A directed closed walk brings every variable up and then down, which separates the cycle where the last variable completes from the cycle before. Clears issued together with a sample, and idle cycles, separate clear priority from the hold behaviour.

// File: rtl/toggle_cov_mon.sv
module toggle_cov_mon #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            smp_valid,
  input  logic [N-1:0]    smp_vec,
  input  logic [N-1:0]    in_mask,
  input  logic [N-1:0]    obs_mask,
  output logic            step_valid,
  output logic [2*N-1:0]  step_codes,
  output logic [IW-1:0]   step_var,
  output logic            proto_err,
  output logic            obs_err,
  output logic [N-1:0]    cov_flags,
  output logic            all_cov
);

  function automatic logic [2*N-1:0] low_bits();
    logic [2*N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) m[2*i] = 1'b1;
    return m;
  endfunction
  localparam logic [2*N-1:0] LOW_MASK = low_bits();

  logic          have_prev;
  logic [N-1:0]  prev, rise_seen, fall_seen;
  logic [N-1:0]  diff, rise, fall, in_diff;
  logic [2*N-1:0] codes_nx;
  logic [IW-1:0] var_nx;
  logic          proto_nx, obs_nx, take;

  assign diff     = smp_vec ^ prev;
  assign rise     = smp_vec & ~prev;
  assign fall     = ~smp_vec & prev;
  assign in_diff  = diff & in_mask;
  assign proto_nx = (in_diff == '0) || ((in_diff & (in_diff - 1'b1)) != '0);
  assign obs_nx   = (diff & obs_mask) == '0;
  assign take     = smp_valid && !clr && have_prev;

  for (genvar g = 0; g < N; g++) begin : g_code
    assign codes_nx[2*g+1:2*g] = {fall[g], rise[g]};
  end

  always_comb begin
    var_nx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (in_diff[i]) var_nx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev  <= 1'b0;
      prev       <= '0;
      rise_seen  <= '0;
      fall_seen  <= '0;
      step_valid <= 1'b0;
      step_codes <= '0;
      step_var   <= '0;
      proto_err  <= 1'b0;
      obs_err    <= 1'b0;
    end else if (clr) begin
      have_prev  <= 1'b0;
      rise_seen  <= '0;
      fall_seen  <= '0;
      step_valid <= 1'b0;
      step_codes <= '0;
      step_var   <= '0;
      proto_err  <= 1'b0;
      obs_err    <= 1'b0;
    end else begin
      step_valid <= take;
      if (smp_valid) begin
        have_prev <= 1'b1;
        prev      <= smp_vec;
      end
      if (take) begin
        step_codes <= codes_nx;
        step_var   <= var_nx;
        proto_err  <= proto_nx;
        obs_err    <= obs_nx;
        if (!proto_nx && !obs_nx) begin
          rise_seen <= rise_seen | rise;
          fall_seen <= fall_seen | fall;
        end
      end
    end
  end

  assign cov_flags = rise_seen & fall_seen;
  assign all_cov   = &cov_flags;

  initial begin
    // R2
    n_range_chk: assert (N >= 2 && N <= 22);
  end

  // R1
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!step_valid && cov_flags == '0));

  // R2
  valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> $past(smp_valid));

  // R2
  no_both_dirs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> ((step_codes & (step_codes >> 1) & LOW_MASK) == '0));

  // R3
  var_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !proto_err) |-> (step_codes[2*step_var +: 2] != 2'b00));

  // R6
  cov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cov_flags & $past(cov_flags)) == $past(cov_flags)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !clr) |=> (!step_valid && $stable(step_codes) && $stable(cov_flags)));

endmodule

// File: tb/sim_toggle_cov_mon.sv
module sim_toggle_cov_mon;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, smp_valid = 1'b0;
  logic [N-1:0] smp_vec = '0;
  logic [N-1:0] in_mask  = 8'b0000_1111;
  logic [N-1:0] obs_mask = 8'b1000_0000;
  logic step_valid, proto_err, obs_err, all_cov;
  logic [2*N-1:0] step_codes;
  logic [IW-1:0] step_var;
  logic [N-1:0] cov_flags;

  toggle_cov_mon #(.N(N), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid), .smp_vec(smp_vec),
    .in_mask(in_mask), .obs_mask(obs_mask), .step_valid(step_valid),
    .step_codes(step_codes), .step_var(step_var), .proto_err(proto_err),
    .obs_err(obs_err), .cov_flags(cov_flags), .all_cov(all_cov));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic m_have = 0, m_sv = 0, m_pe = 0, m_oe = 0;
  logic [N-1:0] m_prev = '0, m_rs = '0, m_fs = '0;
  logic [2*N-1:0] m_codes = '0;
  logic [IW-1:0] m_var = '0;
  logic [N-1:0] cur = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += v[i];
    return c;
  endfunction

  task automatic model(logic v, logic [N-1:0] vec, logic c);
    logic [N-1:0] d;
    m_sv = 0;
    if (c) begin
      m_have = 0; m_rs = '0; m_fs = '0; m_codes = '0; m_var = '0; m_pe = 0; m_oe = 0;
    end else if (v) begin
      if (m_have) begin
        d = vec ^ m_prev;
        m_sv = 1;
        for (int i = 0; i < N; i++)
          m_codes[2*i +: 2] = (vec[i] & ~m_prev[i]) ? 2'b01 : (~vec[i] & m_prev[i]) ? 2'b10 : 2'b00;
        m_var = '0;
        for (int i = N - 1; i >= 0; i--) if (d[i] & in_mask[i]) m_var = IW'(i);
        m_pe = ones(d & in_mask) != 1;
        m_oe = (d & obs_mask) == '0;
        if (!m_pe && !m_oe) begin
          m_rs |= vec & ~m_prev;
          m_fs |= ~vec & m_prev;
        end
      end
      m_have = 1; m_prev = vec;
    end
  endtask

  task automatic compare();
    chk("R2 step_valid", 64'(step_valid), 64'(m_sv));
    chk("R2 step_codes", 64'(step_codes), 64'(m_codes));
    chk("R3 step_var", 64'(step_var), 64'(m_var));
    chk("R4 proto_err", 64'(proto_err), 64'(m_pe));
    chk("R5 obs_err", 64'(obs_err), 64'(m_oe));
    chk("R6 cov_flags", 64'(cov_flags), 64'(m_rs & m_fs));
    chk("R7 all_cov", 64'(all_cov), 64'(&(m_rs & m_fs)));
  endtask

  task automatic apply(logic v, logic [N-1:0] vec, logic c);
    smp_valid = v; smp_vec = vec; clr = c;
    @(negedge clk);
    model(v, vec, c);
    compare();
    smp_valid = 0; clr = 0;
    if (v && !c) cur = vec;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] nv;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset step_valid", 64'(step_valid), 0);
    chk("R1 reset cov_flags", 64'(cov_flags), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: first sample only primes
    apply(1, 8'h00, 0);
    chk("R1 first sample no step", 64'(step_valid), 0);
    // R4/R3: zero inputs changed
    apply(1, 8'h80, 0);
    chk("R4 zero-input step", 64'(proto_err), 1);
    // R4/R3: two inputs changed, lowest index reported
    apply(1, 8'h0C, 0);
    chk("R3 lowest of two", 64'(step_var), 2);
    // R5: no observable change
    apply(1, 8'h0D, 0);
    chk("R5 output still", 64'(obs_err), 1);
    // R9: idle holds
    apply(0, 8'h55, 0);
    chk("R9 idle codes held", 64'(step_codes), 64'(m_codes));
    // R8: clear beats sample
    apply(1, 8'hFF, 1);
    chk("R8 clear wins", 64'(step_valid), 0);
    apply(1, 8'h00, 0);
    chk("R8 sample after clear primes only", 64'(step_valid), 0);
    // R7: closed walk covering every variable
    apply(1, 8'hF1, 0);
    apply(1, 8'h03, 0);
    apply(1, 8'hF7, 0);
    apply(1, 8'h0F, 0);
    apply(1, 8'hFE, 0);
    apply(1, 8'h0C, 0);
    apply(1, 8'hF8, 0);
    chk("R7 not yet complete", 64'(all_cov), 0);
    apply(1, 8'h00, 0);
    chk("R7 walk complete", 64'(all_cov), 1);
    chk("R6 all flags", 64'(cov_flags), 64'hFF);
    // random mix
    apply(1, 8'h00, 1);
    for (int k = 0; k < 400; k++) begin
      int r = $urandom % 20;
      nv = cur ^ (N'($urandom) & 8'hF0);
      if (r < 14) nv ^= N'(1) << ($urandom % 4);
      else if (r < 16) nv ^= 8'h09 << ($urandom % 2);
      if (r == 18) apply(0, nv, 0);
      else if (r == 19 && ($urandom % 4) == 0) apply($urandom % 2, nv, 1);
      else apply(1, nv, 0);
    end
    finish_run();
  end
endmodule